// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Controller

This block governs an 8-bit general-purpose parallel port. Each pin is represented by three drive enables instead of analog levels: a strong pull-down, a strong pull-up and a weak pull-up. A processor writes a byte into the port latch and the latch alone decides the drivers. A 0 pulls the pin to ground. A 1 lets the pin float high or be driven from outside, so the same pin also works as an input.

Two port flavours are chosen by a mode input. In quasi-bidirectional mode, a bit that goes from 0 to 1 gets a short strong pull-up burst. After the burst a weak pull-up holds the level. In open-drain mode every pull-up is off and a 1 leaves the pin three-stated. Reads come from one of two sources. The latch path serves read-modify-write operations. The pin path returns the pin levels after a two-flop synchronizer.

Top module: `qbd_port_ctrl`

## Requirements
- R1: After reset every latch bit is 1. `pull_dn_en` and `strong_up_en` are all 0. `weak_up_en` is all 1 when `od_mode`=0 and all 0 when `od_mode`=1.
- R2: A latch bit holding 0 asserts its `pull_dn_en` bit and deasserts both of its pull-up enables. The change shows from the clock edge that samples the write.
- R3: With `od_mode`=0, a write that changes a latch bit from 0 to 1 asserts that bit's `strong_up_en` for exactly 2 clock periods after the write edge. After that, `weak_up_en` is asserted instead.
- R4: Writing 1 to a latch bit that already holds 1 does not start or restart a strong pull-up burst.
- R5: Writing 0 to a bit whose burst is active ends the burst at that same write edge.
- R6: With `od_mode`=1 no pull-up enable is ever asserted. A latch bit of 1 leaves all three enables of that pin at 0.
- R7: While `rd_latch_en`=1, `rd_data` shows the latch contents, even if `rd_pin_en` is also 1.
- R8: While only `rd_pin_en`=1, `rd_data` shows `pin_in` delayed by two clock edges.
- R9: The latch changes only on writes. Pin levels never alter it.
- R10: With neither read strobe asserted, `rd_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| od_mode | input | 1 | 1 selects open-drain port, 0 selects quasi-bidirectional port |
| wr_en | input | 1 | Latch write strobe |
| wr_data | input | 8 | Byte to store in the latch |
| rd_latch_en | input | 1 | Read the latch (read-modify-write path) |
| rd_pin_en | input | 1 | Read the synchronized pin levels |
| pin_in | input | 8 | Sampled pin levels |
| pull_dn_en | output | 8 | Strong pull-down enable per pin |
| strong_up_en | output | 8 | Strong pull-up enable per pin |
| weak_up_en | output | 8 | Weak pull-up enable per pin |
| rd_data | output | 8 | Read-back data |

## Verification
A write takes effect at the clock edge that samples `wr_en`. The pull-down and pull-up enables are valid just after that edge. A strong burst stays high through the next two edges and is gone after the second. Reads are combinational from the latch and the synchronizer. The latch read is valid in the same cycle, and a pin change appears on `rd_data` only after the second edge that follows it. The bench drives inputs 1 ns after a rising edge and samples 1 ns after the next edge, then checks each enable in each of those cycles. It keeps a model of the latch built from the writes it has issued.

// File: rtl/qbd_port_pkg.sv
package qbd_port_pkg;

  // Source selected for the read-back bus.
  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_PIN   = 2'd1,
    RD_LATCH = 2'd2
  } rd_src_e;

  // Per-pin driver request.
  typedef struct packed {
    logic pull_dn;
    logic strong_up;
    logic weak_up;
  } pin_drive_t;

endpackage

// File: rtl/port_rst_sync.sv
module port_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/port_pin_sync.sv
module port_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_async,
  output logic [WIDTH-1:0] pin_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = pin_async;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= '1;
        end else begin
          stage_q[g] <= stage_d[g];
        end
      end
    end
  endgenerate

  assign pin_sync = stage_q[STAGES-1];

endmodule

// File: rtl/port_bit_ctrl.sv
module port_bit_ctrl
  import qbd_port_pkg::*;
#(
  parameter int BOOST_CYCLES = 2,
  localparam int CNT_W = $clog2(BOOST_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       od_mode,
  input  logic       wr_en,
  input  logic       wr_bit,
  output logic       latch_q,
  output pin_drive_t drive
);

  localparam logic [CNT_W-1:0] BOOST_LOAD = CNT_W'(BOOST_CYCLES);

  logic             latch_d;
  logic             latch_ce;
  logic [CNT_W-1:0] boost_q;
  logic [CNT_W-1:0] boost_d;
  logic             rise;
  logic             boost_on;

  // Latch next state: loaded only by a write.
  always_comb begin
    latch_ce = wr_en;
    latch_d  = wr_bit;
  end

  // Boost counter next state.
  always_comb begin
    rise    = wr_en & wr_bit & ~latch_q;
    boost_d = boost_q;
    if (od_mode) begin
      boost_d = '0;
    end else if (wr_en && !wr_bit) begin
      boost_d = '0;
    end else if (rise) begin
      boost_d = BOOST_LOAD;
    end else if (boost_q != '0) begin
      boost_d = boost_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b1;
    end else if (latch_ce) begin
      latch_q <= latch_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boost_q <= '0;
    end else begin
      boost_q <= boost_d;
    end
  end

  always_comb begin
    boost_on        = (boost_q != '0) & ~od_mode & latch_q;
    drive.pull_dn   = ~latch_q;
    drive.strong_up = boost_on;
    drive.weak_up   = latch_q & ~od_mode & ~boost_on;
  end

endmodule

// File: rtl/port_readback.sv
module port_readback
  import qbd_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             rd_latch_en,
  input  logic             rd_pin_en,
  input  logic [WIDTH-1:0] latch_val,
  input  logic [WIDTH-1:0] pin_val,
  output logic [WIDTH-1:0] rd_data
);

  rd_src_e src;

  always_comb begin
    if (rd_latch_en) begin
      src = RD_LATCH;
    end else if (rd_pin_en) begin
      src = RD_PIN;
    end else begin
      src = RD_NONE;
    end
  end

  always_comb begin
    unique case (src)
      RD_LATCH: rd_data = latch_val;
      RD_PIN:   rd_data = pin_val;
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/qbd_port_ctrl.sv
module qbd_port_ctrl
  import qbd_port_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter int BOOST_CYCLES = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int RST_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             od_mode,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_latch_en,
  input  logic             rd_pin_en,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pull_dn_en,
  output logic [WIDTH-1:0] strong_up_en,
  output logic [WIDTH-1:0] weak_up_en,
  output logic [WIDTH-1:0] rd_data
);

  logic             rst_int_n;
  logic [WIDTH-1:0] latch_vec;
  logic [WIDTH-1:0] pin_synced;
  pin_drive_t       drive_vec [WIDTH];

  port_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  port_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pin_async (pin_in),
    .pin_sync  (pin_synced)
  );

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      port_bit_ctrl #(.BOOST_CYCLES(BOOST_CYCLES)) u_bit (
        .clk     (clk),
        .rst_n   (rst_int_n),
        .od_mode (od_mode),
        .wr_en   (wr_en),
        .wr_bit  (wr_data[i]),
        .latch_q (latch_vec[i]),
        .drive   (drive_vec[i])
      );
      assign pull_dn_en[i]   = drive_vec[i].pull_dn;
      assign strong_up_en[i] = drive_vec[i].strong_up;
      assign weak_up_en[i]   = drive_vec[i].weak_up;
    end
  endgenerate

  port_readback #(.WIDTH(WIDTH)) u_readback (
    .rd_latch_en (rd_latch_en),
    .rd_pin_en   (rd_pin_en),
    .latch_val   (latch_vec),
    .pin_val     (pin_synced),
    .rd_data     (rd_data)
  );

endmodule

// File: rtl/qbd_port_checker.sv
module qbd_port_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             od_mode,
  input logic             wr_en,
  input logic             rd_latch_en,
  input logic             rd_pin_en,
  input logic [WIDTH-1:0] pull_dn_en,
  input logic [WIDTH-1:0] strong_up_en,
  input logic [WIDTH-1:0] weak_up_en,
  input logic [WIDTH-1:0] rd_data
);

  // R2: a pulled-down pin never has a pull-up on it.
  p_no_fight_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_dn_en & (strong_up_en | weak_up_en)) == '0);

  // R3: strong and weak pull-ups never overlap on one pin.
  p_one_pullup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strong_up_en & weak_up_en) == '0);

  // R4: a burst can only begin at a write edge.
  p_burst_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((strong_up_en & ~$past(strong_up_en)) != '0) |-> $past(wr_en));

  // R6: open-drain mode has no pull-ups.
  p_od_no_pullup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    od_mode |-> ((strong_up_en | weak_up_en) == '0));

  // R7: latch read mirrors the pull-down state.
  p_latch_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_latch_en |-> (rd_data == ~pull_dn_en));

  // R9: without a write the latch (seen through pull-down) holds.
  p_latch_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(pull_dn_en));

  // R10: idle read bus is zero.
  p_idle_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_latch_en && !rd_pin_en) |-> (rd_data == '0));

endmodule

bind qbd_port_ctrl qbd_port_checker #(.WIDTH(WIDTH)) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .od_mode      (od_mode),
  .wr_en        (wr_en),
  .rd_latch_en  (rd_latch_en),
  .rd_pin_en    (rd_pin_en),
  .pull_dn_en   (pull_dn_en),
  .strong_up_en (strong_up_en),
  .weak_up_en   (weak_up_en),
  .rd_data      (rd_data)
);

// File: tb/qbd_port_ctrl_bench.sv
`timescale 1ns/1ps
module qbd_port_ctrl_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         od_mode;
  logic         wr_en;
  logic [W-1:0] wr_data;
  logic         rd_latch_en;
  logic         rd_pin_en;
  logic [W-1:0] pin_in;
  logic [W-1:0] pull_dn_en;
  logic [W-1:0] strong_up_en;
  logic [W-1:0] weak_up_en;
  logic [W-1:0] rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  logic [W-1:0] model_latch;

  always #2.5 clk = ~clk;

  qbd_port_ctrl u_qbd_port_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .od_mode      (od_mode),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_latch_en  (rd_latch_en),
    .rd_pin_en    (rd_pin_en),
    .pin_in       (pin_in),
    .pull_dn_en   (pull_dn_en),
    .strong_up_en (strong_up_en),
    .weak_up_en   (weak_up_en),
    .rd_data      (rd_data)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic write_byte(input logic [W-1:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    tick();
    wr_en   = 1'b0;
    model_latch = d;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    od_mode = 1'b0; wr_en = 1'b0; wr_data = '0;
    rd_latch_en = 1'b0; rd_pin_en = 1'b0; pin_in = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    model_latch = '1;
  endtask

  task automatic t_reset_r1();
    do_reset();
    check("R1", "pull_dn", pull_dn_en, '0);
    check("R1", "strong", strong_up_en, '0);
    check("R1", "weak quasi", weak_up_en, '1);
    od_mode = 1'b1; #1;
    check("R1", "weak od", weak_up_en, '0);
    od_mode = 1'b0; #1;
  endtask

  task automatic t_write_zero_r2();
    write_byte(8'h5A);
    check("R2", "pull_dn", pull_dn_en, ~8'h5A);
    check("R2", "weak", weak_up_en, 8'h5A);
    check("R2", "strong", strong_up_en, '0);
  endtask

  task automatic t_boost_r3();
    write_byte(8'h00);
    write_byte(8'h81);
    check("R3", "strong cycle1", strong_up_en, 8'h81);
    check("R3", "weak cycle1", weak_up_en, 8'h00);
    tick();
    check("R3", "strong cycle2", strong_up_en, 8'h81);
    tick();
    check("R3", "strong ended", strong_up_en, 8'h00);
    check("R3", "weak after", weak_up_en, 8'h81);
  endtask

  task automatic t_no_restart_r4();
    write_byte(8'hFF);
    check("R4", "new bits boost", strong_up_en, 8'h7E);
    repeat (3) tick();
    write_byte(8'hFF);
    check("R4", "rewrite 1 no boost", strong_up_en, 8'h00);
    check("R4", "weak kept", weak_up_en, 8'hFF);
  endtask

  task automatic t_cancel_r5();
    write_byte(8'hF0);
    write_byte(8'hFF);
    check("R5", "boost start", strong_up_en, 8'h0F);
    write_byte(8'hFC);
    check("R5", "cancelled", strong_up_en, 8'h0C);
    check("R5", "pull_dn", pull_dn_en, 8'h03);
    tick();
    tick();
    check("R5", "survivors done", strong_up_en, 8'h00);
  endtask

  task automatic t_open_drain_r6();
    od_mode = 1'b1;
    write_byte(8'h00);
    write_byte(8'hA5);
    check("R6", "strong", strong_up_en, 8'h00);
    check("R6", "weak", weak_up_en, 8'h00);
    check("R6", "pull_dn", pull_dn_en, 8'h5A);
    tick();
    check("R6", "strong later", strong_up_en, 8'h00);
    od_mode = 1'b0;
    tick();
    check("R6", "no stale boost", strong_up_en, 8'h00);
  endtask

  task automatic t_reads_r7_r8_r9_r10();
    write_byte(8'h3C);
    pin_in = 8'h00;
    repeat (3) tick();
    check("R10", "idle bus", rd_data, 8'h00);
    rd_pin_en = 1'b1;
    #1;
    check("R8", "pin old", rd_data, 8'h00);
    pin_in = 8'hC3;
    tick();
    check("R8", "after 1 edge", rd_data, 8'h00);
    tick();
    check("R8", "after 2 edges", rd_data, 8'hC3);
    rd_latch_en = 1'b1;
    #1;
    check("R7", "latch priority", rd_data, model_latch);
    rd_pin_en = 1'b0;
    pin_in = 8'hFF;
    repeat (3) tick();
    check("R9", "latch unaffected", rd_data, model_latch);
    check("R9", "pull_dn unaffected", pull_dn_en, ~model_latch);
    rd_latch_en = 1'b0;
    #1;
    check("R10", "idle again", rd_data, 8'h00);
  endtask

  initial begin
    #(200000 * 5);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_write_zero_r2();
    t_boost_r3();
    t_no_restart_r4();
    t_cancel_r5();
    t_open_drain_r6();
    t_reads_r7_r8_r9_r10();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule